// File: doc/BRIEF.md
# Transmit Frame Assembly FIFO

This block sits between a register-mapped data port and a byte-wide transmit path. Software writes 32-bit words. The first word of a frame carries the payload length in its low half, counting the payload only and not the 14-byte header. Each accepted word is stored as four bytes, least significant byte first, in a 2048-byte buffer.

After every stored word the block checks two conditions against the post-write byte count. The first is whether the frame is complete. The second is whether the programmable fill threshold has been met. When both hold, the block starts sending on its own. A separate request input starts a send whatever the fill level.

The frame leaves on a valid/ready byte stream. The stream begins after the two length bytes and marks its final byte with a last flag. It is optionally zero-padded to the minimum frame size. While a frame drains, the block reports busy and takes no writes. It pulses an empty event when the frame has gone out and an error event when a frame is opened with an oversized length. A flush input discards whatever has been gathered.

Top module: `txf_assembler`

## Requirements
- R1: While the buffer is empty, a write opens a frame and its bits [15:0] set the payload length. If that length is above 2032, the word is not stored, nothing is triggered, and `evt_tx_err` is high for exactly the following cycle.
- R2: Each accepted word is stored as four bytes at the current byte count, bits [7:0] first and bits [31:24] last. A word that would take the count past 2048 bytes is dropped. The count never exceeds 2048 and is always a multiple of four.
- R3: A frame counts as complete when the byte count is at least length+16 with `crc_auto`=1, or at least length+20 with `crc_auto`=0. The required count is capped at 2048.
- R4: The threshold is met when `thresh` is not 63 and the byte count is at least 32*`thresh`+4. A `thresh` of 63 disables automatic sending.
- R5: After an accepted write (not rejected under R1), sending starts if R3 and R4 both hold on the updated count, and `tx_valid` is high in the next cycle. A one-cycle `send_req` in the idle state starts a send regardless of R3 and R4.
- R6: The emitted frame is the stored bytes from byte offset 2 onward, length+14 bytes long. Positions beyond the stored count are sent as zero. With `pad_en`=1, a frame shorter than 60 bytes is extended with zero bytes to 60.
- R7: The emitted length is capped at 2046 bytes. In the cycle after the last byte is accepted, `evt_tx_empty` is high for one cycle, the byte count and length are zero, and `busy` is low.
- R8: In the idle state, `flush` clears the byte count and length. It takes priority over a same-cycle write, which is dropped, and a same-cycle `send_req`, which is ignored. A later forced send with `pad_en`=0 then emits 14 zero bytes.
- R9: `busy` is high from the first cycle of a send until the last byte is accepted. While busy, `wr_valid`, `send_req` and `flush` have no effect on the frame in flight or on the buffer contents.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values. `tx_last` is high only with the final byte of the frame.
- R11: After reset the block is idle: `tx_valid`, `busy`, `evt_tx_empty` and `evt_tx_err` are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Data-port write strobe, taken only while `busy` is low |
| wr_data | input | 32 | Data-port word |
| busy | output | 1 | A frame is being streamed; writes are not accepted |
| crc_auto | input | 1 | 1: the downstream path appends the CRC, so the FIFO holds none |
| pad_en | input | 1 | 1: pad short frames with zeros to 60 bytes |
| thresh | input | 6 | Fill threshold in 32-byte steps; 63 turns automatic sending off |
| send_req | input | 1 | Force a send of the current buffer contents |
| flush | input | 1 | Discard the gathered bytes (driven by the TX-error acknowledge) |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| evt_tx_empty | output | 1 | One-cycle pulse after a frame has been fully sent |
| evt_tx_err | output | 1 | One-cycle pulse after an oversized length word |

## Verification
The bench aims at the edges where one byte or one word decides the outcome. It covers the word before and at completeness with and without automatic CRC, which catches a design that sends a word early or late. It covers lengths 2032 and 2033: a wrong comparison either rejects a legal frame or stores a header it should refuse. It also covers a frame that fills the whole buffer, where a missing cap never triggers or emits more than 2046 bytes. Flush-versus-write priority is checked, along with writes, flushes and requests issued while a frame drains. A design that accepted any of them would leave stray bytes, which a following forced empty send exposes as non-zero data. Random frames with random backpressure compare every emitted byte, the padding and the position of the last flag against a byte-level model.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int BUF_BYTES = 2048;
    localparam int MAX_LEN   = 2032;
    localparam int HDR_BYTES = 14;
    localparam int MIN_FRAME = 60;
    localparam int THR_W     = 6;
    localparam int THR_STEP_SH = 5;
    localparam int THR_OFF   = (1 << THR_W) - 1;
    localparam int CNT_W     = $clog2(BUF_BYTES + 1);
    localparam int WORDS     = BUF_BYTES / 4;
    localparam int WADDR_W   = $clog2(WORDS);
    localparam int BADDR_W   = $clog2(BUF_BYTES);
    localparam int OUT_MAX   = BUF_BYTES - 2;

    typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} txf_state_e;

    typedef struct packed {
        txf_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] olen;
        logic             evt_empty;
        logic             evt_err;
    } txf_regs_t;
endpackage

// File: rtl/txf_store.sv
module txf_store
    import txf_pkg::*;
(
    input  logic               clk,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_word,
    input  logic [31:0]        wr_data,
    input  logic [BADDR_W-1:0] rd_addr,
    output logic [7:0]         rd_byte
);
    logic [7:0] lane_out [4];

    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [7:0] mem [WORDS];
        always_ff @(posedge clk) begin
            if (wr_en) begin
                mem[wr_word] <= wr_data[8*l +: 8];
            end
        end
        assign lane_out[l] = mem[rd_addr[BADDR_W-1:2]];
    end

    assign rd_byte = lane_out[rd_addr[1:0]];
endmodule

// File: rtl/txf_sched.sv
module txf_sched
    import txf_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] len,
    input  logic             crc_auto,
    input  logic             pad_en,
    input  logic [THR_W-1:0] thresh,
    output logic             complete,
    output logic             thr_hit,
    output logic [CNT_W-1:0] out_len
);
    localparam int NW = CNT_W + 1;

    logic [NW-1:0]    need;
    logic [NW-1:0]    olen_w;
    logic [CNT_W-1:0] thr_bytes;

    always_comb begin
        // bytes needed: length word + header + payload (+ CRC slot when not automatic)
        need = NW'(len) + NW'(HDR_BYTES + 2) + (crc_auto ? NW'(0) : NW'(4));
        if (need > NW'(BUF_BYTES)) begin
            need = NW'(BUF_BYTES);
        end
        complete = NW'(cnt) >= need;

        thr_bytes = CNT_W'({thresh, {THR_STEP_SH{1'b0}}}) + CNT_W'(4);
        thr_hit   = (thresh != THR_W'(THR_OFF)) && (cnt >= thr_bytes);

        olen_w = NW'(len) + NW'(HDR_BYTES);
        if (pad_en && (olen_w < NW'(MIN_FRAME))) begin
            olen_w = NW'(MIN_FRAME);
        end
        if (olen_w > NW'(OUT_MAX)) begin
            olen_w = NW'(OUT_MAX);
        end
        out_len = olen_w[CNT_W-1:0];
    end
endmodule

// File: rtl/txf_assembler.sv
module txf_assembler
    import txf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    output logic             busy,
    input  logic             crc_auto,
    input  logic             pad_en,
    input  logic [THR_W-1:0] thresh,
    input  logic             send_req,
    input  logic             flush,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             evt_tx_empty,
    output logic             evt_tx_err
);
    txf_regs_t        q, d;
    logic [CNT_W-1:0] nxt_cnt, nxt_len;
    logic             wrote, len_err, we;
    logic             complete, thr_hit;
    logic [CNT_W-1:0] out_len;
    logic [CNT_W-1:0] rd_ptr;
    logic [7:0]       rd_byte;
    logic             sending, final_byte;

    assign sending    = (q.st == ST_SEND);
    assign final_byte = (q.idx == q.olen - CNT_W'(1));

    // stage 1: effect of a data-port write on count and length
    always_comb begin
        nxt_cnt = q.cnt;
        nxt_len = q.len;
        wrote   = 1'b0;
        len_err = 1'b0;
        we      = 1'b0;
        if (!sending && !flush && wr_valid) begin
            if ((q.cnt == '0) && (wr_data[15:0] > 16'(MAX_LEN))) begin
                len_err = 1'b1;
            end else begin
                wrote = 1'b1;
                if (q.cnt == '0) begin
                    nxt_len = wr_data[CNT_W-1:0];
                end
                if (q.cnt <= CNT_W'(BUF_BYTES - 4)) begin
                    we      = 1'b1;
                    nxt_cnt = q.cnt + CNT_W'(4);
                end
            end
        end
    end

    txf_sched u_sched (
        .cnt      (nxt_cnt),
        .len      (nxt_len),
        .crc_auto (crc_auto),
        .pad_en   (pad_en),
        .thresh   (thresh),
        .complete (complete),
        .thr_hit  (thr_hit),
        .out_len  (out_len)
    );

    // stage 2: next register state
    always_comb begin
        d           = q;
        d.evt_empty = 1'b0;
        d.evt_err   = len_err;
        if (!sending) begin
            if (flush) begin
                d.cnt = '0;
                d.len = '0;
            end else begin
                d.cnt = nxt_cnt;
                d.len = nxt_len;
                if (send_req || (wrote && complete && thr_hit)) begin
                    d.st   = ST_SEND;
                    d.idx  = '0;
                    d.olen = out_len;
                end
            end
        end else if (tx_ready) begin
            if (final_byte) begin
                d.st        = ST_IDLE;
                d.cnt       = '0;
                d.len       = '0;
                d.idx       = '0;
                d.evt_empty = 1'b1;
            end else begin
                d.idx = q.idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_ptr = q.idx + CNT_W'(2);

    txf_store u_store (
        .clk     (clk),
        .wr_en   (we),
        .wr_word (q.cnt[BADDR_W-1:2]),
        .wr_data (wr_data),
        .rd_addr (rd_ptr[BADDR_W-1:0]),
        .rd_byte (rd_byte)
    );

    assign busy         = sending;
    assign tx_valid     = sending;
    assign tx_last      = sending && final_byte;
    assign tx_data      = (sending && (rd_ptr < q.cnt) && (q.idx < q.len + CNT_W'(HDR_BYTES)))
                          ? rd_byte : 8'h00;
    assign evt_tx_empty = q.evt_empty;
    assign evt_tx_err   = q.evt_err;
endmodule

// File: rtl/txf_assembler_chk.sv
module txf_assembler_chk
    import txf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic [31:0]      wr_data,
    input logic             busy,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             tx_last,
    input logic             evt_tx_empty,
    input logic             evt_tx_err,
    input logic [CNT_W-1:0] cnt
);
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= CNT_W'(BUF_BYTES)) && (cnt[1:0] == 2'b00));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_last_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_stream_continues_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_last) |=> (tx_valid && busy));

    assert_empty_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_empty |-> ($past(tx_valid && tx_ready && tx_last) && (cnt == '0) && !busy));

    assert_err_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_err |-> $past(wr_valid && !busy && (wr_data[15:0] > 16'(MAX_LEN))));

    assert_events_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_tx_empty, evt_tx_err}));
endmodule

bind txf_assembler txf_assembler_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .busy         (busy),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .evt_tx_empty (evt_tx_empty),
    .evt_tx_err   (evt_tx_err),
    .cnt          (q.cnt)
);

// File: tb/sim_txf_assembler.sv
module sim_txf_assembler;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        busy;
    logic        crc_auto = 1'b1;
    logic        pad_en = 1'b0;
    logic [5:0]  thresh = 6'd63;
    logic        send_req = 1'b0;
    logic        flush = 1'b0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        evt_tx_empty;
    logic        evt_tx_err;

    int nchk = 0;
    int nfail = 0;

    logic [7:0] mdl [2048];
    int         mdl_cnt = 0;
    int         mdl_len = 0;

    logic [7:0] rx_q [$];
    int         last_at = 0;
    bit         frame_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txf_assembler u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .busy(busy),
        .crc_auto(crc_auto), .pad_en(pad_en), .thresh(thresh), .send_req(send_req),
        .flush(flush), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .evt_tx_empty(evt_tx_empty), .evt_tx_err(evt_tx_err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // receiver: random backpressure, samples between edges
    initial begin
        forever begin
            @(negedge clk);
            tx_ready = ($urandom % 4) != 0;
            #1;
            if (tx_valid && tx_ready) begin
                rx_q.push_back(tx_data);
                if (tx_last) begin
                    last_at = rx_q.size();
                    frame_done = 1;
                end
            end
        end
    end

    function automatic bit thr_ok();
        return (thresh != 6'd63) && (mdl_cnt >= 32 * int'(thresh) + 4);
    endfunction

    function automatic bit cmp_ok();
        int need;
        need = mdl_len + 16 + (crc_auto ? 0 : 4);
        if (need > 2048) need = 2048;
        return mdl_cnt >= need;
    endfunction

    function automatic int exp_len();
        int n;
        n = mdl_len + 14;
        if (pad_en && n < 60) n = 60;
        if (n > 2046) n = 2046;
        return n;
    endfunction

    function automatic logic [7:0] exp_byte(input int i);
        return ((i + 2 < mdl_cnt) && (i < mdl_len + 14)) ? mdl[i + 2] : 8'h00;
    endfunction

    task automatic arm_rx();
        rx_q.delete();
        frame_done = 0;
        last_at = 0;
    endtask

    // waits for the frame in flight and compares it with the model
    task automatic get_frame(input string tag);
        int n;
        n = exp_len();
        wait (frame_done);
        chk(rx_q.size() == n, "R6 R7", {tag, " frame length"}, rx_q.size(), n);
        chk(last_at == n, "R10", {tag, " last flag position"}, last_at, n);
        for (int i = 0; i < n && i < rx_q.size(); i++) begin
            if (rx_q[i] !== exp_byte(i)) begin
                chk(0, "R2 R6", $sformatf("%s byte %0d", tag, i), rx_q[i], exp_byte(i));
                break;
            end
        end
        @(negedge clk);
        chk(evt_tx_empty == 1'b1, "R7", {tag, " empty event"}, evt_tx_empty, 1);
        chk(busy == 1'b0, "R7", {tag, " busy after frame"}, busy, 0);
        mdl_cnt = 0;
        mdl_len = 0;
    endtask

    task automatic put(input logic [31:0] w, output bit sent);
        bit exp_err;
        exp_err = 0;
        sent = 0;
        if (mdl_cnt == 0 && w[15:0] > 16'd2032) begin
            exp_err = 1;
        end else begin
            if (mdl_cnt == 0) mdl_len = int'(w[15:0]);
            if (mdl_cnt + 4 <= 2048) begin
                for (int b = 0; b < 4; b++) mdl[mdl_cnt + b] = w[8*b +: 8];
                mdl_cnt += 4;
            end
            sent = thr_ok() && cmp_ok();
        end
        arm_rx();
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(evt_tx_err == exp_err, "R1", "error event", evt_tx_err, exp_err);
        chk(tx_valid == sent, "R3 R4 R5", $sformatf("auto send at count %0d", mdl_cnt), tx_valid, sent);
        if (sent) get_frame("auto");
    endtask

    task automatic force_send(input string tag);
        arm_rx();
        @(negedge clk);
        send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
        chk(tx_valid == 1'b1, "R5", {tag, " forced send starts"}, tx_valid, 1);
        get_frame(tag);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        mdl_cnt = 0;
        mdl_len = 0;
    endtask

    task automatic put_frame(input int len, input int words, output bit sent);
        sent = 0;
        put({$urandom() & 32'hFFFF_0000} | 32'(len), sent);
        for (int k = 1; k < words && !sent; k++) put($urandom(), sent);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        bit s;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(tx_valid == 0, "R11", "tx_valid after reset", tx_valid, 0);
        chk(busy == 0, "R11", "busy after reset", busy, 0);
        chk(evt_tx_empty == 0 && evt_tx_err == 0, "R11", "events after reset", evt_tx_empty + evt_tx_err, 0);

        // R3 R6: length 10, automatic CRC, padding on -> 7 words, 60 bytes out
        thresh = 6'd0; crc_auto = 1'b1; pad_en = 1'b1;
        put_frame(10, 7, s);
        chk(s == 1, "R3", "length 10 sends on seventh word", s, 1);

        // R3: no automatic CRC -> one more word needed
        crc_auto = 1'b0; pad_en = 1'b0;
        put_frame(10, 8, s);
        chk(s == 1, "R3", "length 10 without auto CRC sends on eighth word", s, 1);

        // R1: boundary lengths
        crc_auto = 1'b1;
        put(32'h0000_07F1, s);
        chk(s == 0, "R1", "length 2033 rejected", s, 0);
        thresh = 6'd63;
        put(32'h0000_07F0, s);
        chk(mdl_cnt == 4, "R1", "length 2032 accepted", mdl_cnt, 4);
        do_flush();

        // R4: threshold 2 needs 68 bytes although the frame completes at 20
        thresh = 6'd2;
        put_frame(4, 17, s);
        chk(s == 1, "R4", "threshold 2 sends at 68 bytes", s, 1);

        // R4 R5: threshold off, then forced send
        thresh = 6'd63; pad_en = 1'b1;
        put_frame(20, 12, s);
        chk(s == 0, "R4", "threshold 63 never sends", s, 0);
        force_send("forced");

        // R8: flush beats write and send request in the same cycle
        thresh = 6'd0; pad_en = 1'b0;
        put(32'h0000_0030, s);
        @(negedge clk);
        flush = 1'b1; wr_valid = 1'b1; wr_data = 32'hA5A5_A5A5; send_req = 1'b1;
        @(negedge clk);
        flush = 1'b0; wr_valid = 1'b0; send_req = 1'b0;
        chk(tx_valid == 0, "R8", "flush suppresses send", tx_valid, 1'b0);
        mdl_cnt = 0; mdl_len = 0;
        force_send("after flush R8");

        // R9: inputs during streaming have no effect
        thresh = 6'd63;
        put_frame(30, 12, s);
        arm_rx();
        @(negedge clk);
        send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
        repeat (3) begin
            wr_valid = 1'b1; wr_data = 32'hFFFF_FFFF; flush = 1'b1; send_req = 1'b1;
            @(negedge clk);
        end
        wr_valid = 1'b0; flush = 1'b0; send_req = 1'b0;
        get_frame("busy R9");
        force_send("post-busy R9");

        // R2 R7: full buffer with the requirement capped, then overflow drop
        thresh = 6'd0; crc_auto = 1'b0;
        put_frame(2032, 512, s);
        chk(s == 1, "R3 R7", "capped completeness sends at 2048 bytes", s, 1);
        thresh = 6'd63;
        put_frame(2032, 513, s);
        chk(mdl_cnt == 2048, "R2", "overflow word dropped", mdl_cnt, 2048);
        force_send("overflow R2");

        // random frames
        for (int it = 0; it < 40; it++) begin
            int len;
            len = $urandom % 90;
            pad_en = $urandom % 2;
            crc_auto = $urandom % 2;
            if (it % 5 == 0) begin
                thresh = 6'd63;
                put_frame(len, 1 + $urandom % 30, s);
                force_send("random forced R5");
            end else begin
                thresh = 6'($urandom % 3);
                put_frame(len, 600, s);
                chk(s == 1, "R5", "random frame sent", s, 1);
            end
        end

        @(negedge clk);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule